// File: doc/BRIEF.md
# Fully Populated Binary Burst Sequencer

This controller keeps its whole sequence in a 6-bit binary state register and gives every one of the 64 codes a defined role. Code 0 is the idle state. Codes 1 to 33 are the run states. Idle and the run states together make up the 34-state working cycle. Codes 34 to 63 are a chain of 30 states that the machine uses only while it comes out of reset. Every reset walks the whole chain, one code per clock, before the machine settles in idle. This keeps the spare codes live, and an upset into any spare code leads back to idle.

A start request seen in idle launches a run. During a run the state moves to its successor on every clock without branching. The block drives a burst clock that toggles with the state, a busy flag, and three single-cycle control strobes that mark the first, middle and last run states. After the last run state the machine returns to idle. All outputs are registered, so the burst clock has no glitches.

Top module: `burst_sequencer`

## Requirements
- R1: When `rst` is high at a clock edge, the state becomes code 34, the first reset-chain code. This holds even when `start` is high in the same cycle. All outputs are low after that edge.
- R2: When `rst` is low, the reset chain moves up by one code per clock from 34 to 63, and code 63 goes to idle (code 0). `start` has no effect during the chain. With `start` held high from the release of reset, `busy` first reads high 31 clocks after release.
- R3: In idle the machine stays at code 0 while `start` is low. If `start` is high at an edge in idle, the state becomes code 1 at that edge.
- R4: Run states 1 to 32 each move to the next code on every clock. Code 33 goes to idle. `start` is ignored while a run is in progress.
- R5: `busy` is high exactly while the state is one of the run codes 1 to 33. This gives 33 busy cycles per completed run.
- R6: `burst_clk` is high on odd run codes and low on even run codes and outside a run. This gives 17 pulses per completed run.
- R7: `strobe_first` is high only at code 1, `strobe_mid` only at code 17, and `strobe_last` only at code 33. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, takes priority over start |
| start | input | 1 | Run request, sampled only in idle |
| burst_clk | output | 1 | Burst clock, high on odd run states |
| strobe_first | output | 1 | High in the first run state |
| strobe_mid | output | 1 | High in the middle run state |
| strobe_last | output | 1 | High in the last run state |
| busy | output | 1 | High in every run state |

## Verification
The bench builds the block with its default values, a 6-bit state register and 33 run states. With these values all 64 codes are exercised: each reset walks the full 30-code chain, and each completed run covers every run code. The same values let the bench check the cycle count from reset release to the first run, the 17-pulse burst, and back-to-back runs under a held start. Resets placed in the middle of runs and in the middle of the chain, together with random start requests, show that reset wins over start and that requests during the chain or a run have no effect.

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int STATE_W = 6,
  parameter int RUN_LEN = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic burst_clk,
  output logic strobe_first,
  output logic strobe_mid,
  output logic strobe_last,
  output logic busy
);

  localparam int CODES     = 1 << STATE_W;
  localparam int MID_CODE  = (RUN_LEN + 1) / 2;

  localparam logic [STATE_W-1:0] IDLE    = '0;
  localparam logic [STATE_W-1:0] RUN_S   = STATE_W'(1);
  localparam logic [STATE_W-1:0] RUN_E   = STATE_W'(RUN_LEN);
  localparam logic [STATE_W-1:0] RUN_M   = STATE_W'(MID_CODE);
  localparam logic [STATE_W-1:0] CHAIN_S = STATE_W'(RUN_LEN + 1);
  localparam logic [STATE_W-1:0] CHAIN_E = STATE_W'(CODES - 1);

  logic [STATE_W-1:0] state, nxt;
  logic nxt_run;

  always_comb begin
    if (rst)                                    nxt = CHAIN_S;
    else if (state == IDLE)                     nxt = start ? RUN_S : IDLE;
    else if (state == RUN_E)                    nxt = IDLE;
    else if (state == CHAIN_E)                  nxt = IDLE;
    else if (state < RUN_E || state >= CHAIN_S) nxt = state + 1'b1;
    else                                        nxt = CHAIN_S;
  end

  assign nxt_run = (nxt != IDLE) && (nxt <= RUN_E);

  always_ff @(posedge clk) begin
    state        <= nxt;
    busy         <= nxt_run;
    burst_clk    <= nxt_run && nxt[0];
    strobe_first <= nxt == RUN_S;
    strobe_mid   <= nxt == RUN_M;
    strobe_last  <= nxt == RUN_E;
  end

  assert_reset_entry_R1: assert property (@(posedge clk)
    rst |=> (state == CHAIN_S) && !busy && !burst_clk);

  assert_chain_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state >= CHAIN_S && state != CHAIN_E) |=> state == $past(state) + 1'b1);

  assert_chain_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (state == CHAIN_E) |=> state == IDLE);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE && !start) |=> state == IDLE);

  assert_idle_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE && start) |=> state == RUN_S && strobe_first);

  assert_run_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state != IDLE && state < RUN_E) |=> state == $past(state) + 1'b1);

  assert_run_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state == RUN_E) |=> state == IDLE && !busy);

  assert_busy_range_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state != IDLE && state <= RUN_E));

  assert_burst_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> burst_clk != $past(burst_clk));

  assert_burst_in_run_R6: assert property (@(posedge clk) disable iff (rst)
    burst_clk |-> busy);

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_first, strobe_mid, strobe_last}));

  assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe_first || strobe_mid || strobe_last) |-> busy);

endmodule

// File: tb/burst_sequencer_test.sv
`timescale 1ns/1ps
module burst_sequencer_test;

  localparam int RUN    = 33;
  localparam int CFIRST = 34;
  localparam int CLAST  = 63;
  localparam int MIDC   = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b1;
  logic burst_clk, strobe_first, strobe_mid, strobe_last, busy;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  int ms = -1;
  bit rst_edge = 0;
  bit run_cut = 0;
  int bcnt = 0;
  int pcnt = 0;
  bit prev_busy = 0;

  always #2.5 clk = ~clk;

  burst_sequencer uut (
    .clk(clk), .rst(rst), .start(start),
    .burst_clk(burst_clk), .strobe_first(strobe_first),
    .strobe_mid(strobe_mid), .strobe_last(strobe_last), .busy(busy)
  );

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // behavioural reference: state as a plain integer
  always @(posedge clk) begin
    rst_edge = rst;
    if (rst) begin
      if (ms >= 1 && ms <= RUN) run_cut = 1;
      ms = CFIRST;
    end else if (ms == 0) ms = start ? 1 : 0;
    else if (ms == RUN || ms == CLAST) ms = 0;
    else if (ms > 0) ms = ms + 1;
  end

  always @(negedge clk) begin
    if (ms >= 0) begin
      bit eb;
      string ph;
      eb = (ms >= 1 && ms <= RUN);
      if (rst_edge) ph = "R1";
      else if (ms >= CFIRST) ph = "R2";
      else if (ms == 0) ph = "R3";
      else ph = "R4";
      cmp(ph, "busy", busy, eb);
      cmp("R6", "burst_clk", burst_clk, eb && (ms % 2 == 1));
      cmp("R7", "strobe_first", strobe_first, ms == 1);
      cmp("R7", "strobe_mid", strobe_mid, ms == MIDC);
      cmp("R7", "strobe_last", strobe_last, ms == RUN);
      if (busy) begin
        bcnt++;
        if (burst_clk) pcnt++;
      end
      if (prev_busy && !busy) begin
        if (!run_cut) begin
          cmp("R5", "busy cycles per run", bcnt, RUN);
          cmp("R6", "pulses per run", pcnt, 17);
        end
        bcnt = 0; pcnt = 0; run_cut = 0;
      end
      if (!busy) begin bcnt = 0; pcnt = 0; run_cut = 0; end
      prev_busy = busy;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    int n;
    // R1: reset with start high
    repeat (3) @(negedge clk);
    cmp("R1", "busy under reset with start", busy, 0);
    rst = 1'b0;
    // R2: chain walked with start held, then first run
    n = 0;
    do begin @(negedge clk); n++; end while (!busy && n < 100);
    cmp("R2", "clocks from release to busy", n, CLAST - CFIRST + 2);
    // back-to-back runs under held start
    repeat (3 * (RUN + 1)) @(negedge clk);
    start = 1'b0;
    repeat (RUN + 10) @(negedge clk);
    cmp("R3", "idle holds without start", busy, 0);
    // single pulse, then pulses while busy (R4: ignored)
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (RUN + 5) @(negedge clk);
    // reset in the middle of a run and in the middle of the chain
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    repeat (12) @(negedge clk);
    start = 1'b1;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 3) == 0);
      rst = ($urandom_range(0, 299) == 0);
    end
    rst = 1'b0; start = 1'b0;
    repeat (80) @(negedge clk);
    finish_run();
  end

endmodule